// File: doc/BRIEF.md
# Request-Paced Single-Channel Word Mover

This block is one DMA channel that copies 32-bit words between a memory-side port and a peripheral-side port without processor involvement. Software loads a memory base address, a peripheral base address and an address-stepping register, then writes a command word. The command word holds the byte length, the request line to follow, the direction, the stop-or-repeat choice, the interrupt enable and a go bit. The transfer can be paced by one of sixteen peripheral request lines, so that a device such as an audio serial port can draw samples at its own rate.

Both data ports are single-cycle. In every cycle that the channel moves a word, it reads the source side and writes the destination side together, so one word moves per qualifying cycle. A status word reports the bytes still to go, a pending-interrupt flag and a busy flag. Any read of the status word clears the pending flag. A global enable in a master control register gates all movement. A master status register mirrors channel activity.

Software stops the channel by rewriting the command word with the go bit clear. The remaining count then stays readable, so the driver can work out how far the transfer got and resume from there.

Top module: `reqdma_channel`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, `irq` is low and neither `mem_en` nor `per_en` is asserted.
- R2: Register index 0 is master control (only bit 31 is kept: global enable), 1 is master status (read-only, bit 24 = channel busy), 2 is command, 3 is status (read-only), 4 is memory base, 5 is peripheral base, 6 is the step register, and 7 reads zero; written registers read back as written.
- R3: Writing the command with bit 31 set makes the channel busy, copies both base addresses into the working pointers and loads the remaining field from length bits 15:0 with bits 1:0 forced to zero; a length value N moves floor(N/4)+1 words.
- R4: With command bit 24 set, a word moves only in cycles where `dreq` at the index in command bits 19:16 is high; with bit 24 clear, a word moves in every busy, enabled cycle.
- R5: Command bit 27 set reads memory and writes the peripheral (`per_wdata` = `mem_rdata`); clear reads the peripheral and writes memory (`mem_wdata` = `per_rdata`).
- R6: While master control bit 31 is zero, no word moves, but busy and the remaining count are held.
- R7: Each moved word lowers the remaining field by 4; the word moved while the field is below 4 completes the transfer and reloads the field from the command length (bits 1:0 zeroed).
- R8: On completion with command bit 26 set the channel goes idle; with bit 26 clear it stays busy and restarts from both base addresses.
- R9: Completion with command bit 30 set raises the pending flag, which drives `irq`; a status read clears it, and a completion in the same cycle as a status read leaves it set.
- R10: Writing the command with bit 31 clear drops busy on the next cycle and leaves the remaining field unchanged.
- R11: Step register bits 30:28 give the width (0: 1 byte, 1: 2 bytes, other: 4 bytes); the memory pointer always advances by the width. Bits 18:16 control the peripheral pointer: 0 advances, 1 or 2 holds, and 3 to 7 wrap inside an aligned window of 4, 8, 16, 32 or 64 bytes.
- R12: The status word holds the remaining field in bits 15:0, the pending flag in bit 30 and busy in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dreq | input | NREQ | Peripheral request lines |
| mem_en | output | 1 | Memory-side access this cycle |
| mem_we | output | 1 | Memory-side write |
| mem_addr | output | AW | Memory-side byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| per_en | output | 1 | Peripheral-side access this cycle |
| per_we | output | 1 | Peripheral-side write |
| per_addr | output | AW | Peripheral-side byte address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data, same cycle |
| irq | output | 1 | Completion interrupt (pending flag) |

## Verification
The bench builds the block at its defaults: 32-bit addresses and data, and sixteen request lines. At this size the request index in the command word reaches every line, so pacing on line 2 can be shown while other lines toggle as noise. Full-width addresses also let a peripheral base near the top of the space exercise wrap windows, fixed addressing and plain advance against a behavioural model. Short lengths bring completion, reload, auto-restart and the same-cycle read-versus-completion race within a few dozen cycles.

// File: rtl/reqdma_pkg.sv
`timescale 1ns/1ps
package reqdma_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned LEN_W    = 16;
    localparam int unsigned REQID_W  = 4;
    localparam int unsigned REGIDX_W = 3;

    typedef enum logic [REGIDX_W-1:0] {
        RI_GCTL  = 3'd0,
        RI_GSTAT = 3'd1,
        RI_CMD   = 3'd2,
        RI_STAT  = 3'd3,
        RI_MBASE = 3'd4,
        RI_PBASE = 3'd5,
        RI_STEP  = 3'd6
    } reg_idx_e;

    // command word layout (bit positions are decoded by the sequencer)
    typedef struct packed {
        logic               go;        // 31
        logic               irq_en;    // 30
        logic [1:0]         spare_hi;  // 29:28
        logic               m2p;       // 27
        logic               single;    // 26
        logic               spare25;   // 25
        logic               wait_req;  // 24
        logic [3:0]         spare_mid; // 23:20
        logic [REQID_W-1:0] req_id;    // 19:16
        logic [LEN_W-1:0]   len;       // 15:0
    } cmd_t;

    // step register layout
    typedef struct packed {
        logic       spare31;  // 31
        logic [2:0] width;    // 30:28
        logic [8:0] spare_m;  // 27:19
        logic [2:0] range;    // 18:16
        logic [15:0] spare_l; // 15:0
    } step_t;

    localparam logic [2:0] RNG_ADV   = 3'd0;
    localparam logic [2:0] RNG_HOLD  = 3'd1;
    localparam logic [2:0] RNG_HOLD2 = 3'd2;

    function automatic logic [2:0] step_bytes(input logic [2:0] w);
        case (w)
            3'd0:    return 3'd1;
            3'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [6:0] wrap_mask(input logic [2:0] r);
        logic [6:0] one;
        one = 7'd1;
        if (r < 3'd3) return 7'd0;
        return (one << (r - 3'd1)) - 7'd1;
    endfunction

    function automatic logic [LEN_W-1:0] len_words(input logic [LEN_W-1:0] l);
        return {l[LEN_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/reqdma_addr_step.sv
`timescale 1ns/1ps
module reqdma_addr_step
    import reqdma_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter bit          WRAP_EN = 1'b1
) (
    input  logic [AW-1:0] cur_i,
    input  logic [2:0]    width_i,
    input  logic [2:0]    range_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW-1:0] inc;
    assign inc = AW'(step_bytes(width_i));

    generate
        if (WRAP_EN) begin : g_wrap
            logic [AW-1:0] msk;
            assign msk = AW'(wrap_mask(range_i));
            always_comb begin
                case (range_i)
                    RNG_ADV:             nxt_o = cur_i + inc;
                    RNG_HOLD, RNG_HOLD2: nxt_o = cur_i;
                    default:             nxt_o = (cur_i & ~msk) | ((cur_i + inc) & msk);
                endcase
            end
        end else begin : g_lin
            logic unused_rng;
            assign unused_rng = ^range_i;
            assign nxt_o = cur_i + inc;
        end
    endgenerate
endmodule

// File: rtl/reqdma_regs.sv
`timescale 1ns/1ps
module reqdma_regs
    import reqdma_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REGIDX_W-1:0] reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                busy_i,
    input  logic [LEN_W-1:0]    rem_i,
    input  logic                done_i,
    output logic                gen_o,
    output cmd_t                cmd_o,
    output step_t               step_o,
    output logic [AW-1:0]       mbase_o,
    output logic [AW-1:0]       pbase_o,
    output logic                pend_o,
    output logic                cmd_wr_o,
    output logic                st_rd_o
);
    reg_idx_e idx;
    assign idx      = reg_idx_e'(reg_addr);
    assign cmd_wr_o = reg_wr && (idx == RI_CMD);
    assign st_rd_o  = reg_rd && (idx == RI_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_o   <= 1'b0;
            cmd_o   <= '0;
            step_o  <= '0;
            mbase_o <= '0;
            pbase_o <= '0;
            pend_o  <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (idx)
                    RI_GCTL:  gen_o   <= reg_wdata[REG_W-1];
                    RI_CMD:   cmd_o   <= cmd_t'(reg_wdata);
                    RI_MBASE: mbase_o <= reg_wdata[AW-1:0];
                    RI_PBASE: pbase_o <= reg_wdata[AW-1:0];
                    RI_STEP:  step_o  <= step_t'(reg_wdata);
                    default:  ;
                endcase
            end
            if (done_i && cmd_o.irq_en)
                pend_o <= 1'b1;
            else if (st_rd_o)
                pend_o <= 1'b0;
        end
    end

    always_comb begin
        case (idx)
            RI_GCTL:  reg_rdata = {gen_o, {(REG_W-1){1'b0}}};
            RI_GSTAT: reg_rdata = {7'd0, busy_i, 24'd0};
            RI_CMD:   reg_rdata = cmd_o;
            RI_STAT:  reg_rdata = {busy_i, pend_o, {(REG_W-2-LEN_W){1'b0}}, rem_i};
            RI_MBASE: reg_rdata = REG_W'(mbase_o);
            RI_PBASE: reg_rdata = REG_W'(pbase_o);
            RI_STEP:  reg_rdata = step_o;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/reqdma_seq.sv
`timescale 1ns/1ps
module reqdma_seq
    import reqdma_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NREQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr_i,
    input  logic               new_go_i,
    input  logic [LEN_W-1:0]   new_len_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               single_i,
    input  logic               wait_i,
    input  logic [REQID_W-1:0] req_id_i,
    input  logic               gen_i,
    input  logic [NREQ-1:0]    dreq_i,
    input  logic [AW-1:0]      mbase_i,
    input  logic [AW-1:0]      pbase_i,
    input  logic [2:0]         width_i,
    input  logic [2:0]         range_i,
    output logic               busy_o,
    output logic [LEN_W-1:0]   rem_o,
    output logic               beat_o,
    output logic               done_o,
    output logic [AW-1:0]      mptr_o,
    output logic [AW-1:0]      pptr_o
);
    logic          req_hit;
    logic          last;
    logic [AW-1:0] m_nxt, p_nxt;

    always_comb begin
        req_hit = 1'b0;
        for (int i = 0; i < NREQ; i++)
            if (req_id_i == REQID_W'(i)) req_hit = dreq_i[i];
    end

    assign beat_o = busy_o && gen_i && (!wait_i || req_hit);
    assign last   = (rem_o[LEN_W-1:2] == '0);
    assign done_o = beat_o && last && !cmd_wr_i;

    reqdma_addr_step #(.AW(AW), .WRAP_EN(1'b0)) u_mstep (
        .cur_i(mptr_o), .width_i(width_i), .range_i(range_i), .nxt_o(m_nxt)
    );
    reqdma_addr_step #(.AW(AW), .WRAP_EN(1'b1)) u_pstep (
        .cur_i(pptr_o), .width_i(width_i), .range_i(range_i), .nxt_o(p_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            rem_o  <= '0;
            mptr_o <= '0;
            pptr_o <= '0;
        end else if (cmd_wr_i) begin
            if (new_go_i) begin
                busy_o <= 1'b1;
                rem_o  <= len_words(new_len_i);
                mptr_o <= mbase_i;
                pptr_o <= pbase_i;
            end else begin
                busy_o <= 1'b0;
            end
        end else if (beat_o) begin
            if (last) begin
                rem_o <= len_words(len_i);
                if (single_i) begin
                    busy_o <= 1'b0;
                    mptr_o <= m_nxt;
                    pptr_o <= p_nxt;
                end else begin
                    mptr_o <= mbase_i;
                    pptr_o <= pbase_i;
                end
            end else begin
                rem_o  <= rem_o - LEN_W'(4);
                mptr_o <= m_nxt;
                pptr_o <= p_nxt;
            end
        end
    end
endmodule

// File: rtl/reqdma_channel.sv
`timescale 1ns/1ps
module reqdma_channel
    import reqdma_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned NREQ = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REGIDX_W-1:0] reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NREQ-1:0]     dreq,
    output logic                mem_en,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    output logic                per_en,
    output logic                per_we,
    output logic [AW-1:0]       per_addr,
    output logic [DW-1:0]       per_wdata,
    input  logic [DW-1:0]       per_rdata,
    output logic                irq
);
    logic             gen, pend, cmd_wr, st_rd, busy, beat, done;
    logic [LEN_W-1:0] rem;
    logic [AW-1:0]    mbase, pbase, mptr, pptr;
    cmd_t             cmd_q, cmd_in;
    step_t            step_q;

    assign cmd_in = cmd_t'(reg_wdata);

    reqdma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .rem_i(rem), .done_i(done),
        .gen_o(gen), .cmd_o(cmd_q), .step_o(step_q),
        .mbase_o(mbase), .pbase_o(pbase), .pend_o(pend),
        .cmd_wr_o(cmd_wr), .st_rd_o(st_rd)
    );

    reqdma_seq #(.AW(AW), .NREQ(NREQ)) u_seq (
        .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr),
        .new_go_i(cmd_in.go), .new_len_i(cmd_in.len),
        .len_i(cmd_q.len), .single_i(cmd_q.single), .wait_i(cmd_q.wait_req),
        .req_id_i(cmd_q.req_id), .gen_i(gen), .dreq_i(dreq),
        .mbase_i(mbase), .pbase_i(pbase),
        .width_i(step_q.width), .range_i(step_q.range),
        .busy_o(busy), .rem_o(rem), .beat_o(beat), .done_o(done),
        .mptr_o(mptr), .pptr_o(pptr)
    );

    assign mem_en    = beat;
    assign per_en    = beat;
    assign mem_we    = beat && !cmd_q.m2p;
    assign per_we    = beat &&  cmd_q.m2p;
    assign mem_addr  = mptr;
    assign per_addr  = pptr;
    assign mem_wdata = per_rdata;
    assign per_wdata = mem_rdata;
    assign irq       = pend;
endmodule

// File: rtl/reqdma_checker.sv
`timescale 1ns/1ps
module reqdma_checker
    import reqdma_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mem_en,
    input logic             per_en,
    input logic             mem_we,
    input logic             per_we,
    input logic             irq,
    input logic             busy,
    input logic             gen,
    input logic [LEN_W-1:0] rem,
    input logic             cmd_wr,
    input logic             go_in,
    input logic             single,
    input logic             st_rd
);
    logic last;
    assign last = (rem[LEN_W-1:2] == '0);

    p_side_pair_r5: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (per_en && (mem_we ^ per_we)));

    p_move_gated_r6: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (busy && gen));

    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !last && !cmd_wr) |=> (rem == $past(rem) - LEN_W'(4)));

    p_single_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_en && last && single && !cmd_wr) |=> !busy);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_en));

    p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (st_rd && !mem_en) |=> !irq);

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !go_in) |=> (!busy && $stable(rem)));
endmodule

bind reqdma_channel reqdma_checker u_chk (
    .clk(clk), .rst(rst), .mem_en(mem_en), .per_en(per_en),
    .mem_we(mem_we), .per_we(per_we), .irq(irq), .busy(busy),
    .gen(gen), .rem(rem), .cmd_wr(cmd_wr), .go_in(cmd_in.go),
    .single(cmd_q.single), .st_rd(st_rd)
);

// File: tb/reqdma_channel_tb_top.sv
`timescale 1ns/1ps
module reqdma_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [15:0] dreq = '0;
    logic        mem_en, mem_we, per_en, per_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, per_addr, per_wdata, per_rdata;

    int    vecs = 0, errs = 0, cyc = 0, dq_mode = 0;
    bit    fin = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    assign mem_rdata = {mem_addr[15:0], 16'hA5C3};
    assign per_rdata = ~per_addr;

    reqdma_channel dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dreq(dreq), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_en(per_en),
        .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .irq(irq)
    );

    // behavioural reference state
    bit          m_busy, m_gen, m_pend;
    logic [31:0] m_cmd, m_mb, m_pb, m_step, m_mp, m_pp;
    int          m_rem;

    function automatic logic [31:0] adv(input logic [31:0] a, input bit per);
        int unsigned sb, win;
        int unsigned r;
        sb = (m_step[30:28] == 0) ? 1 : (m_step[30:28] == 1) ? 2 : 4;
        r  = m_step[18:16];
        if (!per || r == 0) return a + sb;
        if (r < 3) return a;
        win = 1 << (r - 1);
        return (a / win) * win + ((a % win + sb) % win);
    endfunction

    function automatic bit m_move();
        return m_busy && m_gen && (!m_cmd[24] || dreq[m_cmd[19:16]]);
    endfunction

    function automatic logic [31:0] exp_rd();
        case (reg_addr)
            3'd0: return {m_gen, 31'd0};
            3'd1: return {7'd0, m_busy, 24'd0};
            3'd2: return m_cmd;
            3'd3: return {m_busy, m_pend, 14'd0, m_rem[15:0]};
            3'd4: return m_mb;
            3'd5: return m_pb;
            3'd6: return m_step;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic compare();
        bit mv;
        mv = m_move();
        vecs++;
        chk("mem_en", 32'(mem_en), 32'(mv));
        chk("per_en", 32'(per_en), 32'(mv));
        chk("mem_we", 32'(mem_we), 32'(mv && !m_cmd[27]));
        chk("per_we", 32'(per_we), 32'(mv && m_cmd[27]));
        chk("irq", 32'(irq), 32'(m_pend));
        chk("reg_rdata", reg_rdata, exp_rd());
        if (mv) begin
            chk("mem_addr", mem_addr, m_mp);
            chk("per_addr", per_addr, m_pp);
            if (m_cmd[27]) chk("per_wdata", per_wdata, {m_mp[15:0], 16'hA5C3});
            else           chk("mem_wdata", mem_wdata, ~m_pp);
        end
    endtask

    task automatic model_update();
        bit mv, done;
        mv = m_move();
        done = 0;
        if (rst) begin
            m_busy = 0; m_gen = 0; m_pend = 0; m_rem = 0;
            m_cmd = 0; m_mb = 0; m_pb = 0; m_step = 0; m_mp = 0; m_pp = 0;
            return;
        end
        if (reg_wr && reg_addr == 3'd2) begin
            if (reg_wdata[31]) begin
                m_busy = 1; m_rem = reg_wdata[15:0] & 16'hFFFC;
                m_mp = m_mb; m_pp = m_pb;
            end else m_busy = 0;
        end else if (mv) begin
            if (m_rem < 4) begin
                done = 1;
                m_rem = m_cmd[15:0] & 16'hFFFC;
                if (m_cmd[26]) begin
                    m_busy = 0; m_mp = adv(m_mp, 0); m_pp = adv(m_pp, 1);
                end else begin
                    m_mp = m_mb; m_pp = m_pb;
                end
            end else begin
                m_rem = m_rem - 4; m_mp = adv(m_mp, 0); m_pp = adv(m_pp, 1);
            end
        end
        if (done && m_cmd[30]) m_pend = 1;
        else if (reg_rd && reg_addr == 3'd3) m_pend = 0;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_gen = reg_wdata[31];
                3'd2: m_cmd = reg_wdata;
                3'd4: m_mb = reg_wdata;
                3'd5: m_pb = reg_wdata;
                3'd6: m_step = reg_wdata;
                default: ;
            endcase
        end
    endtask

    // one clock: inputs were driven at the falling edge
    task automatic tick(input bit do_cmp = 1);
        if (dq_mode == 1) dreq = ((cyc % 3 == 0) ? 16'h0004 : 16'h0000) | (cyc[0] ? 16'h0100 : 16'h0000);
        else if (dq_mode == 2) dreq = 16'hFFFF;
        else if (dq_mode == 3) dreq = 16'hFFFB;
        #1;
        if (do_cmp) compare();
        @(posedge clk);
        model_update();
        cyc++;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_rd = 1; reg_addr = a;
        tick();
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    localparam logic [31:0] GO = 32'h8000_0000, IEN = 32'h4000_0000,
                            M2P = 32'h0800_0000, SGL = 32'h0400_0000,
                            WREQ = 32'h0100_0000, ID2 = 32'h0002_0000;

    initial begin
        @(negedge clk);
        model_update();
        for (int i = 0; i < 3; i++) tick(0);
        rst = 0;

        // R1: reset values on every register index
        tag = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R2: register map readback
        tag = "R2";
        wr(3'd4, 32'h0000_1000);
        wr(3'd5, 32'h8000_0040);
        wr(3'd6, 32'h2001_0000);
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R6: started but globally disabled, requests all high
        tag = "R6";
        dq_mode = 2;
        wr(3'd2, GO | IEN | M2P | SGL | WREQ | ID2 | 32'd12);
        idle(4);
        rd(3'd1);

        // R4: paced by line 2 while other lines toggle; R12 status layout
        tag = "R4";
        dq_mode = 1;
        wr(3'd0, 32'h8000_0000);
        for (int i = 0; i < 6; i++) begin
            tag = "R12"; rd(3'd3);
            tag = "R4";  idle(1);
        end
        idle(8);

        // R9: pending seen, then a status read clears it
        tag = "R9";
        rd(3'd3);
        idle(2);

        // R5/R11: peripheral to memory, no pacing, auto-repeat, 16-byte window
        tag = "R11";
        dq_mode = 0; dreq = '0;
        wr(3'd4, 32'h0000_2000);
        wr(3'd5, 32'hFFFF_FFF4);
        wr(3'd6, 32'h2005_0000);
        tag = "R5";
        wr(3'd2, GO | 32'd24);
        tag = "R8";
        idle(16);

        // R10: halt mid-transfer, count held and readable
        tag = "R10";
        wr(3'd2, 32'd24);
        for (int i = 0; i < 3; i++) rd(3'd3);

        // R3: restart, length with low bits set
        tag = "R3";
        wr(3'd6, 32'h1003_0000);
        wr(3'd2, GO | M2P | SGL | 32'd7);
        rd(3'd3);
        idle(3);

        // R11: byte width, advancing peripheral, gated by line 2 low
        tag = "R11";
        wr(3'd6, 32'h0000_0000);
        dq_mode = 3;
        wr(3'd2, GO | SGL | WREQ | ID2 | 32'd8);
        idle(3);
        dq_mode = 2;
        idle(4);

        // R9: completion and status read in the same cycle
        tag = "R9";
        wr(3'd6, 32'h2001_0000);
        wr(3'd2, GO | IEN | SGL | 32'd0);
        rd(3'd3);
        idle(1);
        rd(3'd3);

        // R7: count steps by four, reload after completion
        tag = "R7";
        wr(3'd2, GO | IEN | SGL | 32'd16);
        for (int i = 0; i < 7; i++) rd(3'd3);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            errs++;
            $display("FAIL watchdog R1: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule